// File: doc/BRIEF.md
# Inverse-Bit Character Set Selector

This block drives the ninth address line of a character-pattern RAM in a machine whose video logic fetches glyph rows during memory refresh cycles. In plain user-defined-graphics operation the CPU's A9 goes straight through to the RAM. In the 128-glyph operation the block remembers the top bit of each fetched character code, the inverse flag, and puts it on the RAM's A9 during the refresh cycle that follows. The glyph row then comes from one of two adjacent 512-byte character sets, so normal and inverse characters can have different shapes. The 128-glyph operation only makes sense once standard user-defined addressing is in use.

All bus strobes (/M1, /MREQ, /RFSH), the data bit D7 and the mode input are asynchronous to the block clock. They pass through two-flop synchronizers on a clock at least eight times the bus clock. The stored inverse bit is taken from the D7 sample one clock older than the detected /M1 rising edge, so D7 changing together with the end of the fetch cannot corrupt it. The mode input is sampled once per refresh cycle, at the falling edge of /MREQ.

A four-state machine follows the bus. `ST_IDLE` means no fetch and no refresh. `ST_FETCH` means /M1 is low. `ST_REFR` means /RFSH is low and no /MREQ fall has been seen yet. `ST_LOCKED` means /RFSH is low and the mode has been captured. The transitions are: idle→fetch on a /M1 fall. Idle or fetch→refresh on a low /RFSH, going straight to locked if /MREQ falls in the same clock. Fetch→idle on a /M1 rise. Refresh→locked on a /MREQ fall. Refresh or locked→idle when /RFSH returns high.

Top module: `glyph_bank_sel`

## Requirements
- R1: After reset the inverse latch and the mode latch both hold 0. A refresh cycle in which /MREQ never falls therefore drives ram_a9 equal to cpu_a9.
- R2: While /RFSH is high (after synchronization), ram_a9 equals cpu_a9 whatever the mode input, D7 or the stored inverse bit are.
- R3: The mode input is captured only at a falling edge of /MREQ while /RFSH is low. Later changes of the mode input inside the same refresh cycle do not change ram_a9.
- R4: In a refresh cycle whose captured mode is 1 (128-glyph), ram_a9 equals the stored inverse bit and does not depend on cpu_a9.
- R5: In a refresh cycle whose captured mode is 0 (pass-through), ram_a9 equals cpu_a9.
- R6: The stored inverse bit is the D7 value from before the /M1 rising edge. A D7 change in the same clock as that edge, or any later change before the next /M1 rise, is not stored.
- R7: A falling edge of /MREQ while /RFSH is high leaves the captured mode unchanged.
- R8: ram_a9 returns to cpu_a9 no more than 4 block clocks after /RFSH rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m1_n | input | 1 | Opcode fetch strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| d7 | input | 1 | Data bit 7 (inverse flag of the character code) |
| cpu_a9 | input | 1 | CPU address bit 9 |
| wide_mode | input | 1 | 1 = 128-glyph selection, 0 = plain pass-through |
| ram_a9 | output | 1 | Address bit 9 to the character RAM |

## Verification
If the inverse latch is wrong, the fault shows only in a refresh cycle with the 128-glyph mode captured: ram_a9 shows the wrong set about three clocks after /RFSH falls and stays wrong for that whole cycle. A wrong mode latch or a stuck state shows up in the same way, or as ram_a9 failing to follow cpu_a9 once /RFSH is high. The directed tests hold cpu_a9 opposite to the expected inverse bit, so each fault gives a visible bit difference. They also line up D7 and mode changes with strobe edges to expose off-by-one-clock sampling.

// File: rtl/glyph_sel_pkg.sv
package glyph_sel_pkg;
    localparam int SYNC_W  = 5;
    localparam int IDX_M1   = 0;
    localparam int IDX_MREQ = 1;
    localparam int IDX_RFSH = 2;
    localparam int IDX_D7   = 3;
    localparam int IDX_MODE = 4;
    localparam logic [SYNC_W-1:0] SYNC_RST = 5'b00111;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_REFR,
        ST_LOCKED
    } sel_state_t;
endpackage

// File: rtl/glyph_sync.sv
module glyph_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/glyph_hist.sv
module glyph_hist #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= cur;
    end
endmodule

// File: rtl/glyph_fsm.sv
module glyph_fsm
    import glyph_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic m1_s,
    input  logic m1_p,
    input  logic mreq_s,
    input  logic mreq_p,
    input  logic rfsh_s,
    input  logic d7_p,
    input  logic mode_s,
    input  logic cpu_a9,
    output logic ram_a9
);
    sel_state_t state, nxt;
    logic inv_q, mode_q;
    logic m1_rise, m1_fall, mreq_fall, mode_take;

    assign m1_rise   = m1_s & ~m1_p;
    assign m1_fall   = ~m1_s & m1_p;
    assign mreq_fall = ~mreq_s & mreq_p;
    assign mode_take = mreq_fall & ~rfsh_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (!rfsh_s)      nxt = mreq_fall ? ST_LOCKED : ST_REFR;
                else if (m1_fall) nxt = ST_FETCH;
            end
            ST_FETCH: begin
                if (!rfsh_s)      nxt = mreq_fall ? ST_LOCKED : ST_REFR;
                else if (m1_rise) nxt = ST_IDLE;
            end
            ST_REFR: begin
                if (rfsh_s)         nxt = ST_IDLE;
                else if (mreq_fall) nxt = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (rfsh_s) nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            inv_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            state <= nxt;
            if (m1_rise)   inv_q  <= d7_p;
            if (mode_take) mode_q <= mode_s;
        end
    end

    always_comb begin
        ram_a9 = cpu_a9;
        unique case (state)
            ST_IDLE, ST_FETCH:  ram_a9 = cpu_a9;
            ST_REFR, ST_LOCKED: ram_a9 = mode_q ? inv_q : cpu_a9;
        endcase
    end

    // R6: stored bit is the D7 sample one clock older than the /M1 rise
    a_r6_d7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        m1_rise |=> inv_q == $past(d7_p));
    a_r6_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !m1_rise |=> $stable(inv_q));
    // R3: mode taken only at /MREQ fall inside refresh
    a_r3_mode_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mode_take |=> mode_q == $past(mode_s));
    // R7: no other event moves the mode latch
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_take |=> $stable(mode_q));
    // R8: refresh states are left once /RFSH is seen high
    a_r8_leave_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_s |=> (state == ST_IDLE || state == ST_FETCH));
endmodule

// File: rtl/glyph_bank_sel.sv
module glyph_bank_sel
    import glyph_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic m1_n,
    input  logic mreq_n,
    input  logic rfsh_n,
    input  logic d7,
    input  logic cpu_a9,
    input  logic wide_mode,
    output logic ram_a9
);
    logic [SYNC_W-1:0] raw_bus, s_bus;
    logic [2:0]        h_cur, h_prev;

    always_comb begin
        raw_bus           = '0;
        raw_bus[IDX_M1]   = m1_n;
        raw_bus[IDX_MREQ] = mreq_n;
        raw_bus[IDX_RFSH] = rfsh_n;
        raw_bus[IDX_D7]   = d7;
        raw_bus[IDX_MODE] = wide_mode;
    end

    glyph_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_bus),
        .sync_out(s_bus)
    );

    assign h_cur = {s_bus[IDX_D7], s_bus[IDX_MREQ], s_bus[IDX_M1]};

    glyph_hist #(
        .WIDTH  (3),
        .RST_VAL(3'b011)
    ) u_hist (
        .clk  (clk),
        .rst_n(rst_n),
        .cur  (h_cur),
        .prev (h_prev)
    );

    glyph_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .m1_s  (s_bus[IDX_M1]),
        .m1_p  (h_prev[0]),
        .mreq_s(s_bus[IDX_MREQ]),
        .mreq_p(h_prev[1]),
        .rfsh_s(s_bus[IDX_RFSH]),
        .d7_p  (h_prev[2]),
        .mode_s(s_bus[IDX_MODE]),
        .cpu_a9(cpu_a9),
        .ram_a9(ram_a9)
    );

    // R2: with /RFSH high for two samples the CPU line passes through
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bus[IDX_RFSH] && $past(s_bus[IDX_RFSH])) |-> ram_a9 == cpu_a9);
endmodule

// File: tb/tb_glyph_bank_sel.sv
module tb_glyph_bank_sel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m1_n = 1'b1, mreq_n = 1'b1, rfsh_n = 1'b1;
    logic d7 = 1'b0, cpu_a9 = 1'b0, wide_mode = 1'b0;
    logic ram_a9;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    glyph_bank_sel dut (
        .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .mreq_n(mreq_n),
        .rfsh_n(rfsh_n), .d7(d7), .cpu_a9(cpu_a9),
        .wide_mode(wide_mode), .ram_a9(ram_a9)
    );

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        #1;
        total++;
        if (ram_a9 !== exp) begin
            bad++;
            $display("FAIL %s: ram_a9=%b expected=%b at %0t", req, ram_a9, exp, $time);
        end
    endtask

    task automatic fetch(input logic v);
        m1_n = 1'b0; mreq_n = 1'b0; d7 = v;
        waitn(8);
        m1_n = 1'b1; mreq_n = 1'b1;
        waitn(8);
    endtask

    task automatic enter_refresh(input logic md);
        rfsh_n = 1'b0;
        waitn(4);
        wide_mode = md; mreq_n = 1'b0;
        waitn(8);
    endtask

    task automatic leave_refresh;
        rfsh_n = 1'b1; mreq_n = 1'b1;
        waitn(8);
    endtask

    task automatic t_reset;
        cpu_a9 = 1'b1; check("R1", 1'b1);
        cpu_a9 = 1'b0; check("R1", 1'b0);
        rfsh_n = 1'b0; wide_mode = 1'b1; cpu_a9 = 1'b1;
        waitn(8);
        check("R1", 1'b1);
        rfsh_n = 1'b1; wide_mode = 1'b0;
        waitn(8);
    endtask

    task automatic t_wide;
        fetch(1'b1);
        cpu_a9 = 1'b0;
        enter_refresh(1'b1);
        check("R4", 1'b1);
        cpu_a9 = 1'b1; check("R4", 1'b1);
        leave_refresh();
        fetch(1'b0);
        cpu_a9 = 1'b1;
        enter_refresh(1'b1);
        check("R4", 1'b0);
        leave_refresh();
    endtask

    task automatic t_udg;
        fetch(1'b1);
        cpu_a9 = 1'b0;
        enter_refresh(1'b0);
        check("R5", 1'b0);
        cpu_a9 = 1'b1; check("R5", 1'b1);
        leave_refresh();
    endtask

    task automatic t_pass;
        fetch(1'b1);
        enter_refresh(1'b1);
        leave_refresh();
        wide_mode = 1'b1;
        cpu_a9 = 1'b0; check("R2", 1'b0);
        cpu_a9 = 1'b1; check("R2", 1'b1);
        m1_n = 1'b0; d7 = 1'b0; cpu_a9 = 1'b0;
        waitn(4);
        check("R2", 1'b0);
        m1_n = 1'b1;
        waitn(8);
    endtask

    task automatic t_mode_hold;
        fetch(1'b1);
        cpu_a9 = 1'b0;
        enter_refresh(1'b1);
        wide_mode = 1'b0;
        waitn(8);
        check("R3", 1'b1);
        leave_refresh();
    endtask

    task automatic t_d7_race;
        m1_n = 1'b0; mreq_n = 1'b0; d7 = 1'b0;
        waitn(8);
        m1_n = 1'b1; mreq_n = 1'b1; d7 = 1'b1;
        waitn(8);
        cpu_a9 = 1'b1;
        enter_refresh(1'b1);
        check("R6", 1'b0);
        d7 = 1'b0; waitn(4); d7 = 1'b1; waitn(4);
        check("R6", 1'b0);
        leave_refresh();
    endtask

    task automatic t_outside;
        fetch(1'b1);
        cpu_a9 = 1'b0;
        enter_refresh(1'b0);
        leave_refresh();
        wide_mode = 1'b1; mreq_n = 1'b0; waitn(8);
        rfsh_n = 1'b0; waitn(8);
        check("R7", 1'b0);
        rfsh_n = 1'b1; mreq_n = 1'b1; wide_mode = 1'b0;
        waitn(8);
    endtask

    task automatic t_latency;
        fetch(1'b1);
        cpu_a9 = 1'b0;
        enter_refresh(1'b1);
        check("R8", 1'b1);
        rfsh_n = 1'b1;
        waitn(4);
        check("R8", 1'b0);
        mreq_n = 1'b1;
        waitn(8);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: ram_a9=%b expected=progress", ram_a9);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        waitn(4);
        rst_n = 1'b1;
        waitn(4);
        t_reset();
        t_wide();
        t_udg();
        t_pass();
        t_mode_hold();
        t_d7_race();
        t_outside();
        t_latency();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule